// File: doc/BRIEF.md
# SDRAM Burst Engine with Clock Suspend

This block is a synthesizable device-side model of a single-bank synchronous DRAM data path. It accepts commands on a small command bus, keeps one row open in a register array, and runs four-beat read and write bursts. Reads return data two clocks after the command. Writes take their first word on the same edge as the command.

The clock-enable input gives clock suspend. When clock enable is sampled low while the row is open, the engine runs one more edge and then freezes. The burst counter, the latency stage and the column pointer all hold their values. A frozen read keeps its last word on the output, and a frozen write does not store incoming data. Once clock enable is sampled high again, the burst continues from the beat where it stopped, so no beat is skipped and none is repeated. A memory controller model or a controller testbench can use the block as a cycle-accurate stand-in for the device when it tests suspend handling.

Top module: `sdr_burst_engine`

## Requirements
- R1: After a synchronous reset, `dout_oe` is 0, `dout` is 0 and `busy` is 0, and no row is open.
- R2: A READ accepted on edge E with the row open puts beat 0 on `dout` with `dout_oe` high after edge E+2 (with no suspend). One beat follows on each edge after that, four beats in all. `dout_oe` falls after edge E+6. The column sequence starts at `col` and wraps inside its aligned group of four, so column c+k is (c & ~3) | ((c + k) & 3).
- R3: A WRITE accepted on edge E stores `din` at `col` on edge E. The next three unfrozen edges store `din` at the following columns, using the same wrap as R2.
- R4: If `cke` is sampled low on an edge while the row is open, that edge still executes normally and the next edge is frozen.
- R5: An edge is frozen exactly when `cke` was sampled low on the previous edge with the row open. The edge on which `cke` is first sampled high again is still frozen, and the edge after it runs.
- R6: On a frozen edge every command is ignored. A PRECHARGE presented there neither closes the row nor ends the burst.
- R7: During a frozen read, `dout` and `dout_oe` keep the values they had after the last unfrozen edge. This holds when the freeze lands after the final beat as well.
- R8: `din` presented on a frozen edge of a write burst is not stored.
- R9: After a suspend ends, the burst resumes at the next beat. Every beat of the burst is output or stored exactly once.
- R10: READ and WRITE with no open row are ignored. `cke` sampled low with no open row does not freeze the next edge.
- R11: `busy` is high from the edge that accepts a READ until the edge that outputs its fourth beat, and from the edge that accepts a WRITE until the edge that stores its fourth beat. While `dout_oe` is low, `dout` is zero.
- R12: An unfrozen PRECHARGE closes the row, ends any burst and drops `dout_oe` and `busy` after that edge. A new READ or WRITE ends the burst in progress.
- Command codes on `cmd`: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE. Any other code acts as NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable, sampled each edge |
| cmd | input | 3 | Command code |
| col | input | 4 | Column address for READ/WRITE |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, zero when not driven |
| dout_oe | output | 1 | Read data valid / output enable |
| busy | output | 1 | A burst beat or the read latency is pending |

## Verification
The bench places the freeze at three points in a read: on the first beat, in the middle and just after the last beat. A design that lets the beat counter run on during a freeze skips words. One that restarts the counter repeats words. One that drops the output enable while frozen loses the held word at the end of the burst. Write bursts are frozen at their start, in the middle and near the end while junk data and PRECHARGE commands are driven during the frozen edges. A design that does not gate writes or commands while frozen then corrupts the stored data or closes the row. Directed cases cover these faults:
- an entry delay or exit delay that is off by one edge, which shifts the observed beats;
- clock enable low with no row open, which freezes the engine by mistake;
- reads and writes with no open row, which are accepted when they should be ignored;
- burst termination by PRECHARGE and by a new READ, which leaves a burst running when it should end.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    localparam int DATA_W    = 16;
    localparam int COL_W     = 4;
    localparam int BURST_LEN = 4;
    localparam int CAS_LAT   = 2;
    localparam int DEPTH     = 1 << COL_W;
    localparam int GRP_W     = $clog2(BURST_LEN);
    localparam int BEAT_W    = $clog2(BURST_LEN + 1);
    localparam int LAT_W     = $clog2(CAS_LAT + 1);

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    // Decoded command, already qualified by the open row and the freeze
    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
    } cmd_dec_t;

    typedef struct packed {
        logic [LAT_W-1:0]  lat;
        logic [BEAT_W-1:0] left;
        logic [COL_W-1:0]  col;
    } rd_ctx_t;

    typedef struct packed {
        logic [BEAT_W-1:0] left;
        logic [COL_W-1:0]  col;
    } wr_ctx_t;

    // Next column inside the aligned burst group
    function automatic logic [COL_W-1:0] col_step(input logic [COL_W-1:0] c);
        logic [GRP_W-1:0] low;
        low = c[GRP_W-1:0] + GRP_W'(1);
        return {c[COL_W-1:GRP_W], low};
    endfunction
endpackage

// File: rtl/sdr_suspend_ctl.sv
module sdr_suspend_ctl
    import sdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic row_open,
    output logic frozen
);
    always_ff @(posedge clk) begin
        if (rst) frozen <= 1'b0;
        else     frozen <= !cke && row_open;
    end

    // R4
    enter_susp_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke && row_open) |=> frozen);
    // R5
    leave_susp_chk: assert property (@(posedge clk) disable iff (rst)
        cke |=> !frozen);
    // R10
    idle_no_susp_chk: assert property (@(posedge clk) disable iff (rst)
        !row_open |=> !frozen);
endmodule

// File: rtl/sdr_row_ctl.sv
module sdr_row_ctl
    import sdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frozen,
    input  logic [2:0] cmd,
    output logic       row_open,
    output cmd_dec_t   dec
);
    always_comb begin
        dec = '0;
        if (!frozen) begin
            case (cmd)
                CMD_ACT: dec.act = !row_open;
                CMD_RD:  dec.rd  = row_open;
                CMD_WR:  dec.wr  = row_open;
                CMD_PRE: dec.pre = row_open;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          row_open <= 1'b0;
        else if (dec.act) row_open <= 1'b1;
        else if (dec.pre) row_open <= 1'b0;
    end

    // R6
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && !rst) |=> $stable(row_open));
endmodule

// File: rtl/sdr_row_store.sv
module sdr_row_store
    import sdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [COL_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [COL_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)                                 cells[i] <= '0;
            else if (we && waddr == COL_W'(i))       cells[i] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frozen,
    input  cmd_dec_t          dec,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [COL_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [COL_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              busy
);
    rd_ctx_t rd_q;
    wr_ctx_t wr_q;

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = wr_q.col;
        wr_data = din;
        if (!frozen) begin
            if (dec.wr) begin
                wr_en   = 1'b1;
                wr_addr = col;
            end else if (!dec.rd && !dec.pre && wr_q.left != '0) begin
                wr_en = 1'b1;
            end
        end
    end

    assign rd_addr = rd_q.col;
    assign busy    = (rd_q.lat != '0) || (rd_q.left != '0) || (wr_q.left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= '0;
            wr_q    <= '0;
            dout    <= '0;
            dout_oe <= 1'b0;
        end else if (!frozen) begin
            if (dec.pre) begin
                rd_q    <= '0;
                wr_q    <= '0;
                dout    <= '0;
                dout_oe <= 1'b0;
            end else if (dec.rd) begin
                rd_q.lat  <= LAT_W'(CAS_LAT - 1);
                rd_q.left <= BEAT_W'(BURST_LEN);
                rd_q.col  <= col;
                wr_q.left <= '0;
                dout      <= '0;
                dout_oe   <= 1'b0;
            end else if (dec.wr) begin
                wr_q.left <= BEAT_W'(BURST_LEN - 1);
                wr_q.col  <= col_step(col);
                rd_q      <= '0;
                dout      <= '0;
                dout_oe   <= 1'b0;
            end else begin
                if (wr_q.left != '0) begin
                    wr_q.left <= wr_q.left - BEAT_W'(1);
                    wr_q.col  <= col_step(wr_q.col);
                end
                if (rd_q.lat != '0) begin
                    rd_q.lat <= rd_q.lat - LAT_W'(1);
                end else if (rd_q.left != '0) begin
                    dout      <= rd_data;
                    dout_oe   <= 1'b1;
                    rd_q.left <= rd_q.left - BEAT_W'(1);
                    rd_q.col  <= col_step(rd_q.col);
                end else begin
                    dout    <= '0;
                    dout_oe <= 1'b0;
                end
            end
        end
    end

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && !rst) |=> ($stable(dout) && $stable(dout_oe)));
    // R9
    beat_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_q.left <= BEAT_W'(BURST_LEN)) && (wr_q.left < BEAT_W'(BURST_LEN)));
    // R11
    oe_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0));
    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && !rst) |=> ($stable(rd_q) && $stable(wr_q)));
endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
    import sdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic [2:0]        cmd,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              busy
);
    logic              frozen;
    logic              row_open;
    cmd_dec_t          dec;
    logic              st_we;
    logic [COL_W-1:0]  st_waddr;
    logic [DATA_W-1:0] st_wdata;
    logic [COL_W-1:0]  st_raddr;
    logic [DATA_W-1:0] st_rdata;

    sdr_suspend_ctl u_susp (
        .clk(clk), .rst(rst), .cke(cke), .row_open(row_open), .frozen(frozen)
    );

    sdr_row_ctl u_row (
        .clk(clk), .rst(rst), .frozen(frozen), .cmd(cmd),
        .row_open(row_open), .dec(dec)
    );

    sdr_row_store u_store (
        .clk(clk), .rst(rst), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
        .raddr(st_raddr), .rdata(st_rdata)
    );

    sdr_burst_seq u_seq (
        .clk(clk), .rst(rst), .frozen(frozen), .dec(dec), .col(col), .din(din),
        .rd_data(st_rdata), .wr_en(st_we), .wr_addr(st_waddr), .wr_data(st_wdata),
        .rd_addr(st_raddr), .dout(dout), .dout_oe(dout_oe), .busy(busy)
    );

    // R8
    wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        frozen |-> !st_we);
    // R10
    no_row_chk: assert property (@(posedge clk) disable iff (rst)
        (!row_open && !frozen) |=> !busy);
    // R12
    pre_end_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.pre && !rst) |=> (!busy && !dout_oe && !row_open));
endmodule

// File: tb/tb_sdr_burst_engine.sv
module tb_sdr_burst_engine;
    import sdr_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              cke;
    logic [2:0]        cmd;
    logic [COL_W-1:0]  col;
    logic [DATA_W-1:0] din;
    logic [DATA_W-1:0] dout;
    logic              dout_oe;
    logic              busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [DATA_W-1:0] ref_mem [DEPTH];

    // {is_write, column, first low-cke edge, low-cke length}
    localparam int NVEC = 9;
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 4'd0,  4'd0, 4'd0},
        {1'b1, 4'd5,  4'd1, 4'd2},
        {1'b1, 4'd10, 4'd0, 4'd3},
        {1'b1, 4'd15, 4'd2, 4'd2},
        {1'b0, 4'd0,  4'd0, 4'd0},
        {1'b0, 4'd5,  4'd2, 4'd2},
        {1'b0, 4'd10, 4'd3, 4'd3},
        {1'b0, 4'd15, 4'd5, 4'd2},
        {1'b0, 4'd6,  4'd0, 4'd1}
    };

    sdr_burst_engine dut (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .col(col), .din(din),
        .dout(dout), .dout_oe(dout_oe), .busy(busy)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [COL_W-1:0] grp_col(input logic [COL_W-1:0] c, input int k);
        logic [1:0] low;
        low = c[1:0] + 2'(k);
        return {c[COL_W-1:2], low};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One burst with a window of low clock enable; expectations from R2-R9
    task automatic run_burst(input bit is_wr, input logic [3:0] c, input int s,
                             input int len, input int tag);
        int  n        = 0;
        bit  prev_cke = 1'b1;
        for (int e = 0; e < 14; e++) begin
            bit frz = !prev_cke;
            bit ck  = !(len != 0 && e >= s && e < s + len);
            int m;
            cke = ck;
            din = 16'hDEAD;
            if (e == 0) begin
                cmd = is_wr ? CMD_WR : CMD_RD;
                col = c;
            end else if (frz) begin
                cmd = CMD_PRE;
                col = 4'hF;
            end else begin
                cmd = CMD_NOP;
            end
            if (is_wr && !frz && n < 4) begin
                din = 16'hA000 + 16'(tag * 16 + n);
                ref_mem[grp_col(c, n)] = din;
            end
            if (!frz) n++;
            prev_cke = ck;
            tick();
            m = n - 1;
            if (is_wr) begin
                chk(busy == (m < 3), "R3 R8 R11 write busy", busy, (m < 3));
            end else begin
                bit          oe_e = (m >= 2 && m <= 5);
                logic [15:0] d_e  = oe_e ? ref_mem[grp_col(c, m - 2)] : 16'h0;
                chk(dout_oe == oe_e, "R2 R4 R5 R7 oe", dout_oe, oe_e);
                chk(dout == d_e, "R2 R6 R7 R9 data", dout, d_e);
                chk(busy == (m < 5), "R11 read busy", busy, (m < 5));
            end
        end
        cmd = CMD_NOP;
        cke = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; cke = 1'b1; cmd = CMD_NOP; col = '0; din = '0;
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        chk(dout_oe == 1'b0, "R1 oe", dout_oe, 0);
        chk(dout == '0, "R1 dout", dout, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        // R10 read with no open row
        cmd = CMD_RD; col = 4'd0; tick();
        cmd = CMD_NOP;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(!dout_oe && !busy, "R10 read without row", {dout_oe, busy}, 0);
        end
        cmd = CMD_ACT; tick(); cmd = CMD_NOP; tick();

        for (int v = 0; v < NVEC; v++) begin
            run_burst(VEC[v][12], VEC[v][11:8], int'(VEC[v][7:4]), int'(VEC[v][3:0]), v);
            tick();
        end

        // R12 PRECHARGE in mid burst
        cmd = CMD_RD; col = 4'd0; tick();
        cmd = CMD_NOP; tick(); tick();
        chk(dout_oe == 1'b1, "R12 beat0 before precharge", dout_oe, 1);
        cmd = CMD_PRE; tick(); cmd = CMD_NOP;
        chk(!dout_oe && !busy, "R12 precharge ends burst", {dout_oe, busy}, 0);
        // R10 write without row is not stored
        cmd = CMD_WR; col = 4'd1; din = 16'h5555; tick();
        cmd = CMD_NOP; tick(); tick();
        // R10 low cke with no row must not freeze the next edge
        cke = 1'b0; cmd = CMD_ACT; tick();
        cke = 1'b1;
        run_burst(1'b0, 4'd0, 0, 0, 20);
        tick();
        // R12 new READ ends current read
        cmd = CMD_RD; col = 4'd0; tick();
        cmd = CMD_NOP; tick(); tick(); tick();
        cmd = CMD_RD; col = 4'd8; tick(); cmd = CMD_NOP;
        chk(dout_oe == 1'b0, "R12 new read drops oe", dout_oe, 0);
        tick(); tick();
        chk(dout_oe && dout == ref_mem[8], "R12 new read data", dout, ref_mem[8]);
        // R1 reset in mid burst
        rst = 1'b1; tick(); rst = 1'b0;
        chk(!dout_oe && !busy && dout == '0, "R1 reset mid burst", {dout_oe, busy, dout}, 0);
        tick();
        finish_run();
    end
endmodule